// File: doc/BRIEF.md
# Six-State Mealy Sequencer on JK Storage

This block is a small synchronous Mealy machine with one serial input `x` and one output `z`. It walks a fixed six-state transition table, with the states named a to f. The state sits in three JK flip-flops that are built as explicit modules. Combinational excitation logic works out the J and K value of each flip-flop from the present state and `x`. The table is implemented as given, without any state minimisation.

The three-bit state codes follow adjacency rules. Two kinds of state pair receive codes that differ in a single bit:

- pairs that lead to the same next state under the same input;
- pairs that are reached from a common predecessor.

A parameter selects how the excitation logic is built:

- **Hand-minimised equations.** These use the don't-care entries of the JK rule and the two unused codes.
- **Direct rule.** The JK rule is applied bit by bit to a next-state lookup.

A second parameter sets the code that a synchronous reset loads. The present state is brought out so that a surrounding design, or a bench, can observe it.

Top module: `jkm_mealy`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is the reset code given by `INIT_CODE`, whatever `x` is. The default is state a, code 000.
- R2: The state codes, written as bits [2:0], are a=000, f=001, e=010, c=011, d=110 and b=111. `cur_state` only ever holds one of these six codes. The unused codes 100 and 101 would move to a on the next clock.
- R3: Each of the pairs {f,c}, {d,b}, {a,f}, {c,b} and {a,e} has codes that differ in exactly one bit.
- R4: Transitions from states a, e and f:
  - from a: x=0 goes to a and x=1 goes to e;
  - from e: x=0 goes to f;
  - from f: x=0 goes to a.
- R5: Transitions from states b, c and d:
  - from b: x=0 goes to c;
  - from c: x=0 goes to a and x=1 goes to f;
  - from d: x=0 goes to c and x=1 goes to b.
- R6: `z` is 1 exactly when the present state is b or d and `x` is 1. It responds to `x` in the same cycle, with no clock edge in between.
- R7: With x=1, states b, e and f stay where they are on every clock, for as long as x stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to `INIT_CODE` |
| x | input | 1 | Serial input bit |
| z | output | 1 | Mealy output: state b or d with x=1 |
| cur_state | output | 3 | Present state code (R2 encoding) |

## Verification
The bench builds two copies of the machine. `u0` uses the minimised equations and resets to a. `u1` uses the direct JK rule and resets to d.

State d is never the next state of any transition, so `u1` is the only way its rows of the table can be reached. Running both copies also compares the two excitation variants on the same stimulus.

Random `x` sequences, with occasional resets, then visit every row of the table from both starting points. The codes observed during that run are used afterwards to confirm the adjacency pairs.

// File: rtl/jkm_pkg.sv
package jkm_pkg;
  localparam int SW = 3;

  localparam logic [SW-1:0] CODE_A = 3'b000;
  localparam logic [SW-1:0] CODE_F = 3'b001;
  localparam logic [SW-1:0] CODE_E = 3'b010;
  localparam logic [SW-1:0] CODE_C = 3'b011;
  localparam logic [SW-1:0] CODE_D = 3'b110;
  localparam logic [SW-1:0] CODE_B = 3'b111;

  function automatic logic code_legal(input logic [SW-1:0] s);
    return (s == CODE_A) || (s == CODE_B) || (s == CODE_C) ||
           (s == CODE_D) || (s == CODE_E) || (s == CODE_F);
  endfunction

  function automatic logic [SW-1:0] next_code(input logic [SW-1:0] s, input logic x);
    logic [SW-1:0] n;
    unique case (s)
      CODE_A:  n = x ? CODE_E : CODE_A;
      CODE_F:  n = x ? CODE_F : CODE_A;
      CODE_E:  n = x ? CODE_E : CODE_F;
      CODE_C:  n = x ? CODE_F : CODE_A;
      CODE_D:  n = x ? CODE_B : CODE_C;
      CODE_B:  n = x ? CODE_B : CODE_C;
      default: n = CODE_A;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/jkm_jk_ff.sv
module jkm_jk_ff #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else begin
      unique case ({j, k})
        2'b00: q <= q;
        2'b01: q <= 1'b0;
        2'b10: q <= 1'b1;
        2'b11: q <= ~q;
      endcase
    end
  end
endmodule

// File: rtl/jkm_excite.sv
module jkm_excite
  import jkm_pkg::*;
#(
  parameter bit MIN_EQ = 1'b1
) (
  input  logic [SW-1:0] q,
  input  logic          x,
  output logic [SW-1:0] j,
  output logic [SW-1:0] k
);
  generate
    if (MIN_EQ) begin : g_min
      always_comb begin
        j[2] = 1'b0;
        k[2] = ~x | ~q[1];
        j[1] = x & ~q[2] & ~q[0];
        k[1] = ~q[2] & (q[0] | ~x);
        j[0] = q[1] & (q[2] | ~x);
        k[0] = (~x & ~q[2]) | (q[2] & ~q[1]);
      end
    end else begin : g_rule
      logic [SW-1:0] nxt;
      always_comb nxt = next_code(q, x);
      for (genvar i = 0; i < SW; i++) begin : g_bit
        // Q=0 half: J follows the next bit, K free (held 0).
        // Q=1 half: K is the inverted next bit, J free (held 0).
        always_comb begin
          j[i] = q[i] ? 1'b0     : nxt[i];
          k[i] = q[i] ? ~nxt[i]  : 1'b0;
        end
      end
    end
  endgenerate

  // R2
  always_comb begin
    if (!code_legal(q)) begin
      unused_clear_chk: assert ((j == '0) && ((k & q) == q))
        else $error("unused code %b does not clear to a", q);
    end
  end
endmodule

// File: rtl/jkm_mealy.sv
module jkm_mealy
  import jkm_pkg::*;
#(
  parameter logic [2:0] INIT_CODE = 3'b000,
  parameter bit         MIN_EQ    = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       x,
  output logic       z,
  output logic [2:0] cur_state
);
  logic [SW-1:0] q_r;
  logic [SW-1:0] j_w;
  logic [SW-1:0] k_w;

  jkm_excite #(.MIN_EQ(MIN_EQ)) u_exc (
    .q (q_r),
    .x (x),
    .j (j_w),
    .k (k_w)
  );

  generate
    for (genvar i = 0; i < SW; i++) begin : g_ff
      jkm_jk_ff #(.RST_VAL(INIT_CODE[i])) u_ff (
        .clk (clk),
        .rst (rst),
        .j   (j_w[i]),
        .k   (k_w[i]),
        .q   (q_r[i])
      );
    end
  endgenerate

  // b and d are the only legal codes with both upper bits set.
  assign z         = x & q_r[2] & q_r[1];
  assign cur_state = q_r;

  // R1
  rst_init_chk: assert property (@(posedge clk) rst |=> cur_state == INIT_CODE)
    else $error("reset did not load init code");
  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    code_legal(cur_state)) else $error("illegal state code");
  // R4
  a_to_e_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_state == CODE_A && x) |=> cur_state == CODE_E) else $error("a,x=1 not to e");
  // R5
  d_to_c_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_state == CODE_D && !x) |=> cur_state == CODE_C) else $error("d,x=0 not to c");
  // R6
  z_hi_chk: assert property (@(posedge clk) disable iff (rst)
    ((cur_state == CODE_B || cur_state == CODE_D) && x) |-> z) else $error("z low in b/d");
  // R6
  z_lo_chk: assert property (@(posedge clk) disable iff (rst)
    !x |-> !z) else $error("z high with x=0");
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (x && (cur_state == CODE_B || cur_state == CODE_E || cur_state == CODE_F))
    |=> $stable(cur_state)) else $error("self loop left");
endmodule

// File: tb/sim_jkm_mealy.sv
module sim_jkm_mealy;
  localparam int LA = 0, LB = 1, LC = 2, LD = 3, LE = 4, LF = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x   = 1'b0;
  always #2 clk = ~clk;

  logic       z0, z1;
  logic [2:0] s0, s1;

  jkm_mealy #(.INIT_CODE(3'b000), .MIN_EQ(1'b1)) u0 (
    .clk(clk), .rst(rst), .x(x), .z(z0), .cur_state(s0));
  jkm_mealy #(.INIT_CODE(3'b110), .MIN_EQ(1'b0)) u1 (
    .clk(clk), .rst(rst), .x(x), .z(z1), .cur_state(s1));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int m0 = LA, m1 = LD;
  logic [2:0] seen [6];
  bit         seen_ok [6];

  // R2 codes
  function automatic logic [2:0] code_of(input int l);
    case (l)
      LA: return 3'b000;
      LB: return 3'b111;
      LC: return 3'b011;
      LD: return 3'b110;
      LE: return 3'b010;
      default: return 3'b001;
    endcase
  endfunction

  function automatic int next_of(input int l, input bit xv);
    case (l)
      LA: return xv ? LE : LA;
      LB: return xv ? LB : LC;
      LC: return xv ? LF : LA;
      LD: return xv ? LB : LC;
      LE: return xv ? LE : LF;
      default: return xv ? LF : LA;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input bit rv, input int src, input bit xv);
    if (rv) return "R1 reset";
    if (xv && (src == LB || src == LE || src == LF)) return "R7 hold";
    if (src == LA || src == LE || src == LF) return "R4 a/e/f row";
    return "R5 b/c/d row";
  endfunction

  task automatic step(input bit xv, input bit rv);
    int src0, src1;
    x = xv; rst = rv;
    #1;
    // R6: z follows x combinationally
    chk("R6 z u0", {2'b0, z0}, {2'b0, xv && (m0 == LB || m0 == LD)});
    chk("R6 z u1", {2'b0, z1}, {2'b0, xv && (m1 == LB || m1 == LD)});
    src0 = m0; src1 = m1;
    @(posedge clk);
    m0 = rv ? LA : next_of(m0, xv);
    m1 = rv ? LD : next_of(m1, xv);
    @(negedge clk);
    chk({tag_of(rv, src0, xv), " u0"}, s0, code_of(m0));
    chk({tag_of(rv, src1, xv), " u1"}, s1, code_of(m1));
    seen[m0] = s0; seen_ok[m0] = 1'b1;
    seen[m1] = s1; seen_ok[m1] = 1'b1;
  endtask

  task automatic adj(input int p, input int q);
    checks++;
    if (!seen_ok[p] || !seen_ok[q] || $countones(seen[p] ^ seen[q]) != 1) begin
      fails++;
      $display("FAIL R3 adjacency %0d/%0d: actual=%b,%b expected one-bit distance",
               p, q, seen[p], seen[q]);
    end
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin
      seen[i] = 3'b000;
      seen_ok[i] = 1'b0;
    end
    @(negedge clk);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    // directed: u0 a->e->e->f->f->a, u1 d->b->b->c->f->a
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    // R1: reset with x=1 mid-run
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    for (int n = 0; n < 600; n++) begin
      step(1'($urandom_range(0, 1)), ($urandom_range(0, 40) == 0));
    end
    // R2: every model state reached with its own code seen at the port
    for (int l = 0; l < 6; l++) chk("R2 code seen", seen[l], code_of(l));
    // R3
    adj(LF, LC); adj(LD, LB); adj(LA, LF); adj(LC, LB); adj(LA, LE);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule